// File: doc/BRIEF.md
# Ring-Attached Direct-Mapped Data Cache Controller

This block is the data cache of one processor core on a slotted ring interconnect. It serves one request at a time. Each request is the head of an address queue, with a read/write flag, and a write request also has the head of a write-data queue. A read hit pushes the addressed word into a read-data queue. A write hit overwrites the cached word. In both cases the block then pops the queues it consumed. Addresses with bit 31 set belong to I/O and are left untouched.

On a miss the block works through the ring. It waits for empty slots passing through its ring stage and fills them with request slots. The first is a line-read request for the missing line. If the line being replaced holds modified data, eight write-data slots follow with the old words, and then a write-address slot for the old line. The block then watches a separate return stream and takes each word addressed to its own core number into the line. After the last word arrives, the line is marked valid and the stalled request completes as a hit. Only one miss is outstanding, because the address queue is not popped until the request is served.

Top module: `ring_dcache`

## Requirements
- R1: A request whose address bit 31 is 1 is ignored. While it is held, `aq_pop`, `wq_pop` and `rq_push` stay 0 and no slot is injected onto the ring.
- R2: A read hit presented in a lookup cycle raises `aq_pop` and `rq_push` together for exactly one cycle, starting at the next clock edge. `rq_data` then holds the addressed word, with word select address[4:2].
- R3: A write hit stores `wq_data` in the addressed word and raises `aq_pop` and `wq_pop` together for one cycle at the next edge. The line is marked modified.
- R4: On a miss the first injected slot has kind 1 (line read), source `CORE_ID` and payload {address[31:5], 5'b0}.
- R5: If the replaced line is valid and modified, the line read is followed by eight kind-2 (write data) slots carrying the old words 0 to 7 in that order. Then comes one kind-3 (write address) slot with payload {old tag, index, 5'b0}. All of these slots have source `CORE_ID`.
- R6: A slot is injected only in a cycle whose incoming kind is 0 (empty). Every cycle without an injection forwards the incoming kind, source and payload unchanged, one cycle later.
- R7: After the last injection of a miss, each return beat with `ret_valid`=1 and `ret_dest`=`CORE_ID` fills the next word of the line, from 0 to 7. Beats with another destination, or with `ret_valid`=0, change nothing.
- R8: Once the eighth word has been taken, the stalled request is handled as a hit. Its `aq_pop` goes high at the second clock edge after the edge that took that word, and not earlier.
- R9: A refilled line is clean. Evicting it later injects only the line-read slot.
- R10: While a miss is being serviced, `aq_pop`, `wq_pop` and `rq_push` stay 0.
- R11: After reset all lines are invalid. The queue outputs are 0 and the ring output carries kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aq_valid | input | 1 | Address queue not empty |
| aq_addr | input | 32 | Byte address at the head of the address queue |
| aq_write | input | 1 | Head request is a write |
| aq_pop | output | 1 | Pop the address queue |
| wq_data | input | 32 | Head of the write-data queue |
| wq_pop | output | 1 | Pop the write-data queue |
| rq_push | output | 1 | Push `rq_data` into the read-data queue |
| rq_data | output | 32 | Read-hit word |
| ring_in_kind | input | 3 | Kind of the incoming ring slot, 0 = empty |
| ring_in_src | input | 4 | Source/destination field of the incoming slot |
| ring_in_word | input | 32 | Payload of the incoming slot |
| ring_out_kind | output | 3 | Kind of the outgoing slot |
| ring_out_src | output | 4 | Source/destination field of the outgoing slot |
| ring_out_word | output | 32 | Payload of the outgoing slot |
| ret_valid | input | 1 | Return stream beat present |
| ret_dest | input | 4 | Core number the returned word belongs to |
| ret_word | input | 32 | Returned data word |

## Verification
A wrong tag or valid bit shows up at the ports in the cycle after the lookup. Either a spurious `aq_pop` arrives with stale `rq_data`, or an unexpected line-read slot appears on the ring at the next empty slot. A wrong modified bit only shows at the next eviction of that line, as eight extra or missing write-data slots. A fill written to the wrong word, or a foreign return beat that was accepted, stays hidden until a later read hit on that word returns a different value. The bench therefore reads back every word of every line it refills, and it evicts lines both right after writing them and right after refilling them.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int WORD_W    = 32;
  localparam int SRC_W     = 4;
  localparam int KIND_W    = 3;
  localparam int LINE_WDS  = 8;
  localparam int OFS_W     = $clog2(LINE_WDS);
  localparam int BYTE_W    = 2;

  localparam logic [KIND_W-1:0] KIND_NULL    = 3'd0;
  localparam logic [KIND_W-1:0] KIND_LINE_RD = 3'd1;
  localparam logic [KIND_W-1:0] KIND_WR_DATA = 3'd2;
  localparam logic [KIND_W-1:0] KIND_WR_ADDR = 3'd3;

  typedef enum logic [2:0] {
    ST_LOOK, ST_DONE, ST_REQ_LINE, ST_WB_DATA, ST_WB_ADDR, ST_FILL
  } ctl_state_e;
endpackage

// File: rtl/rdc_tag_store.sv
module rdc_tag_store #(
  parameter int LINES = 16,
  parameter int IDX_W = $clog2(LINES),
  parameter int TAG_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic             vict_valid,
  output logic             vict_dirty,
  output logic [TAG_W-1:0] vict_tag,
  input  logic             set_dirty,
  input  logic             fill_done,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  logic [LINES-1:0] valid_r;
  logic [LINES-1:0] dirty_r;
  logic [TAG_W-1:0] tags [LINES];

  assign vict_valid = valid_r[look_idx];
  assign vict_dirty = dirty_r[look_idx];
  assign vict_tag   = tags[look_idx];
  assign hit        = valid_r[look_idx] && (tags[look_idx] == look_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r <= '0;
      dirty_r <= '0;
    end else if (fill_done) begin
      valid_r[fill_idx] <= 1'b1;
      dirty_r[fill_idx] <= 1'b0;
    end else if (set_dirty) begin
      dirty_r[look_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) tags[fill_idx] <= fill_tag;
  end

  assert_dirty_on_valid_R3: assert property (@(posedge clk) disable iff (rst)
    set_dirty |-> valid_r[look_idx]);

  assert_refill_clean_R9: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> (valid_r[$past(fill_idx)] && !dirty_r[$past(fill_idx)]));
endmodule

// File: rtl/rdc_line_ram.sv
module rdc_line_ram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rdc_ring_stage.sv
module rdc_ring_stage
  import rdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [WORD_W-1:0] in_word,
  input  logic              inj,
  input  logic [KIND_W-1:0] inj_kind,
  input  logic [SRC_W-1:0]  inj_src,
  input  logic [WORD_W-1:0] inj_word,
  output logic [KIND_W-1:0] out_kind,
  output logic [SRC_W-1:0]  out_src,
  output logic [WORD_W-1:0] out_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_kind <= KIND_NULL;
      out_src  <= '0;
      out_word <= '0;
    end else if (inj) begin
      out_kind <= inj_kind;
      out_src  <= inj_src;
      out_word <= inj_word;
    end else begin
      out_kind <= in_kind;
      out_src  <= in_src;
      out_word <= in_word;
    end
  end

  assert_inject_empty_only_R6: assert property (@(posedge clk) disable iff (rst)
    inj |-> (in_kind == KIND_NULL));

  assert_forward_intact_R6: assert property (@(posedge clk) disable iff (rst)
    !inj |=> (out_kind == $past(in_kind) && out_src == $past(in_src)
              && out_word == $past(in_word)));
endmodule

// File: rtl/ring_dcache.sv
module ring_dcache
  import rdc_pkg::*;
#(
  parameter int          LINES   = 16,
  parameter logic [3:0]  CORE_ID = 4'd3,
  localparam int IDX_W  = $clog2(LINES),
  localparam int LSB_W  = OFS_W + BYTE_W,
  localparam int TAG_W  = WORD_W - LSB_W - IDX_W,
  localparam int RAM_AW = IDX_W + OFS_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        aq_valid,
  input  logic [31:0] aq_addr,
  input  logic        aq_write,
  output logic        aq_pop,
  input  logic [31:0] wq_data,
  output logic        wq_pop,
  output logic        rq_push,
  output logic [31:0] rq_data,
  input  logic [2:0]  ring_in_kind,
  input  logic [3:0]  ring_in_src,
  input  logic [31:0] ring_in_word,
  output logic [2:0]  ring_out_kind,
  output logic [3:0]  ring_out_src,
  output logic [31:0] ring_out_word,
  input  logic        ret_valid,
  input  logic [3:0]  ret_dest,
  input  logic [31:0] ret_word
);
  localparam logic [OFS_W-1:0] LAST_WD = OFS_W'(LINE_WDS - 1);

  ctl_state_e       st;
  logic [IDX_W-1:0] m_idx;
  logic [TAG_W-1:0] m_tag, v_tag;
  logic             v_dirty;
  logic [OFS_W-1:0] cnt;
  logic             primed;

  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic [OFS_W-1:0] req_ofs;
  logic             is_cached, slot_free, ret_mine;
  logic             hit, vict_valid, vict_dirty;
  logic [TAG_W-1:0] vict_tag;
  logic             set_dirty, fill_done;
  logic             ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [31:0]      ram_wdata, ram_rdata;
  logic             inj;
  logic [KIND_W-1:0] inj_kind;
  logic [31:0]      inj_word;

  assign req_ofs   = aq_addr[LSB_W-1:BYTE_W];
  assign req_idx   = aq_addr[LSB_W+IDX_W-1:LSB_W];
  assign req_tag   = aq_addr[WORD_W-1:LSB_W+IDX_W];
  assign is_cached = aq_valid && !aq_addr[WORD_W-1];
  assign slot_free = (ring_in_kind == KIND_NULL);
  assign ret_mine  = ret_valid && (ret_dest == CORE_ID);

  rdc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .look_idx(req_idx), .look_tag(req_tag),
    .hit(hit), .vict_valid(vict_valid), .vict_dirty(vict_dirty), .vict_tag(vict_tag),
    .set_dirty(set_dirty), .fill_done(fill_done), .fill_idx(m_idx), .fill_tag(m_tag)
  );

  rdc_line_ram #(.ADDR_W(RAM_AW), .DATA_W(WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  rdc_ring_stage u_ring (
    .clk(clk), .rst(rst),
    .in_kind(ring_in_kind), .in_src(ring_in_src), .in_word(ring_in_word),
    .inj(inj), .inj_kind(inj_kind), .inj_src(CORE_ID), .inj_word(inj_word),
    .out_kind(ring_out_kind), .out_src(ring_out_src), .out_word(ring_out_word)
  );

  assign rq_data = ram_rdata;

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = {req_idx, req_ofs};
    ram_wdata = wq_data;
    ram_raddr = (st == ST_WB_DATA) ? {m_idx, cnt} : {req_idx, req_ofs};
    set_dirty = 1'b0;
    fill_done = 1'b0;
    inj       = 1'b0;
    inj_kind  = KIND_NULL;
    inj_word  = '0;
    case (st)
      ST_LOOK: begin
        if (is_cached && hit && aq_write) begin
          ram_we    = 1'b1;
          set_dirty = 1'b1;
        end
      end
      ST_REQ_LINE: begin
        inj      = slot_free;
        inj_kind = KIND_LINE_RD;
        inj_word = {m_tag, m_idx, {LSB_W{1'b0}}};
      end
      ST_WB_DATA: begin
        inj      = slot_free && primed;
        inj_kind = KIND_WR_DATA;
        inj_word = ram_rdata;
      end
      ST_WB_ADDR: begin
        inj      = slot_free;
        inj_kind = KIND_WR_ADDR;
        inj_word = {v_tag, m_idx, {LSB_W{1'b0}}};
      end
      ST_FILL: begin
        if (ret_mine) begin
          ram_we    = 1'b1;
          ram_waddr = {m_idx, cnt};
          ram_wdata = ret_word;
          fill_done = (cnt == LAST_WD);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_LOOK;
      aq_pop  <= 1'b0;
      wq_pop  <= 1'b0;
      rq_push <= 1'b0;
      cnt     <= '0;
      primed  <= 1'b0;
      m_idx   <= '0;
      m_tag   <= '0;
      v_tag   <= '0;
      v_dirty <= 1'b0;
    end else begin
      aq_pop  <= 1'b0;
      wq_pop  <= 1'b0;
      rq_push <= 1'b0;
      case (st)
        ST_LOOK: begin
          if (is_cached) begin
            if (hit) begin
              aq_pop  <= 1'b1;
              wq_pop  <= aq_write;
              rq_push <= !aq_write;
              st      <= ST_DONE;
            end else begin
              m_idx   <= req_idx;
              m_tag   <= req_tag;
              v_tag   <= vict_tag;
              v_dirty <= vict_valid && vict_dirty;
              st      <= ST_REQ_LINE;
            end
          end
        end
        ST_DONE: st <= ST_LOOK;
        ST_REQ_LINE: begin
          if (slot_free) begin
            cnt    <= '0;
            primed <= 1'b0;
            st     <= v_dirty ? ST_WB_DATA : ST_FILL;
          end
        end
        ST_WB_DATA: begin
          if (inj) begin
            cnt    <= cnt + 1'b1;
            primed <= 1'b0;
            if (cnt == LAST_WD) st <= ST_WB_ADDR;
          end else begin
            primed <= 1'b1;
          end
        end
        ST_WB_ADDR: if (slot_free) st <= ST_FILL;
        ST_FILL: begin
          if (ret_mine) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_WD) st <= ST_LOOK;
          end
        end
        default: st <= ST_LOOK;
      endcase
    end
  end

  assert_io_never_served_R1: assert property (@(posedge clk) disable iff (rst)
    aq_pop |-> $past(aq_valid && !aq_addr[31]));

  assert_pop_pairing_R2: assert property (@(posedge clk) disable iff (rst)
    aq_pop |-> (rq_push ^ wq_pop));

  assert_no_stray_push_R10: assert property (@(posedge clk) disable iff (rst)
    (rq_push || wq_pop) |-> aq_pop);

  assert_quiet_during_miss_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FILL || st == ST_WB_DATA) |-> !aq_pop);
endmodule

// File: tb/ring_dcache_test.sv
`timescale 1ns/1ps
module ring_dcache_test;
  localparam logic [3:0] ID = 4'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        aq_valid = 0, aq_write = 0;
  logic [31:0] aq_addr = 0, wq_data = 0;
  logic        aq_pop, wq_pop, rq_push;
  logic [31:0] rq_data;
  logic [2:0]  ring_in_kind = 0, ring_out_kind;
  logic [3:0]  ring_in_src = 0, ring_out_src;
  logic [31:0] ring_in_word = 0, ring_out_word;
  logic        ret_valid = 0;
  logic [3:0]  ret_dest = 0;
  logic [31:0] ret_word = 0;

  ring_dcache #(.LINES(16), .CORE_ID(ID)) uut (.*);

  int checks = 0, fails = 0;
  bit done = 0, ring_on = 0;

  // reference model state
  bit          mv [16];
  bit          md [16];
  logic [22:0] mt [16];
  logic [31:0] mdat [16][8];
  logic [31:0] backing [int];
  logic [38:0] exp_q [$];

  function automatic logic [31:0] mem_rd(input int wa);
    if (backing.exists(wa)) return backing[wa];
    return (wa * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, expv);
    end
  endtask

  // ring driver and per-clock ring checker (R4 R5 R6)
  logic [15:0] lf = 16'hACE1;
  logic [2:0]  p_kind = 0;
  logic [3:0]  p_src = 0;
  logic [31:0] p_word = 0;
  always @(negedge clk) begin
    if (ring_on) begin
      if (p_kind != 3'd0 || ring_out_kind == 3'd0) begin
        chk({ring_out_kind, ring_out_src, ring_out_word} == {p_kind, p_src, p_word},
            "R6 forward", {ring_out_kind, ring_out_src, ring_out_word}, {p_kind, p_src, p_word});
      end else if (exp_q.size() == 0) begin
        chk(1'b0, "R1/R6 unexpected injection", {ring_out_kind, ring_out_src, ring_out_word}, 0);
      end else begin
        chk({ring_out_kind, ring_out_src, ring_out_word} == exp_q[0],
            "R4/R5 injected slot", {ring_out_kind, ring_out_src, ring_out_word}, exp_q[0]);
        void'(exp_q.pop_front());
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[1:0] != 2'b00) begin
        ring_in_kind = 3'd1 + 3'(lf[4:2] % 3'd7);
        ring_in_src  = 4'd9;
        ring_in_word = {lf, lf ^ 16'h1234};
      end else begin
        ring_in_kind = 3'd0;
        ring_in_src  = 4'd0;
        ring_in_word = 32'd0;
      end
      p_kind = ring_in_kind; p_src = ring_in_src; p_word = ring_in_word;
    end
  end

  task automatic do_req(input logic [31:0] addr, input bit wr, input logic [31:0] wd);
    logic [3:0]  idx = addr[8:5];
    logic [22:0] tg = addr[31:9];
    logic [2:0]  ofs = addr[4:2];
    bit miss = !(mv[idx] && mt[idx] == tg);
    int base = int'({addr[31:5], 3'b000});
    int n;
    if (miss) begin
      exp_q.push_back({3'd1, ID, addr[31:5], 5'b0});
      if (mv[idx] && md[idx]) begin
        for (int w = 0; w < 8; w++) begin
          exp_q.push_back({3'd2, ID, mdat[idx][w]});
          backing[int'({mt[idx], idx, 3'(w)})] = mdat[idx][w];
        end
        exp_q.push_back({3'd3, ID, mt[idx], idx, 5'b0});
      end
    end
    @(negedge clk);
    aq_valid = 1; aq_addr = addr; aq_write = wr; wq_data = wd;
    if (miss) begin
      n = 0;
      while (exp_q.size() != 0 && n < 2000) begin
        @(negedge clk);
        n++;
        chk(!aq_pop && !rq_push && !wq_pop, "R10 quiet while injecting", {aq_pop, rq_push, wq_pop}, 0);
      end
      chk(exp_q.size() == 0, "R5 all slots injected", exp_q.size(), 0);
      @(negedge clk);
      ret_valid = 1; ret_dest = ID + 4'd1; ret_word = 32'hDEAD_BEEF;   // foreign beat (R7)
      @(negedge clk);
      ret_valid = 0; ret_dest = ID; ret_word = 32'hBAD0_BAD0;          // idle beat (R7)
      for (int w = 0; w < 8; w++) begin
        @(negedge clk);
        chk(!aq_pop, "R10 quiet during fill", aq_pop, 0);
        ret_valid = 1; ret_dest = ID; ret_word = mem_rd(base + w);
        mdat[idx][w] = ret_word;
      end
      mv[idx] = 1; mt[idx] = tg; md[idx] = 0;
      @(negedge clk);
      ret_valid = 0;
      chk(!aq_pop, "R8 not early", aq_pop, 0);
    end
    @(negedge clk);
    chk(aq_pop, miss ? "R8 pop after fill" : "R2/R3 hit pop timing", aq_pop, 1);
    if (wr) begin
      chk(wq_pop && !rq_push, "R3 write pops", {wq_pop, rq_push}, 2'b10);
      mdat[idx][ofs] = wd; md[idx] = 1;
    end else begin
      chk(rq_push && !wq_pop, "R2 read push", {rq_push, wq_pop}, 2'b10);
      chk(rq_data == mdat[idx][ofs], "R2/R7 read data", rq_data, mdat[idx][ofs]);
    end
    aq_valid = 0; aq_write = 0;
    @(negedge clk);
    chk(!aq_pop && !rq_push && !wq_pop, "R2 single-cycle pulse", {aq_pop, rq_push, wq_pop}, 0);
  endtask

  initial begin
    logic [31:0] ra;
    logic [15:0] r = 16'h1F2B;
    for (int i = 0; i < 16; i++) begin mv[i] = 0; md[i] = 0; mt[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!aq_pop && !wq_pop && !rq_push && ring_out_kind == 3'd0, "R11 reset outputs",
        {aq_pop, wq_pop, rq_push, ring_out_kind}, 0);
    ring_on = 1;
    @(negedge clk);
    do_req(32'h0000_0100, 0, 0);                 // R11 first access misses, R4 clean
    do_req(32'h0000_0104, 0, 0);                 // R2 hit
    do_req(32'h0000_0108, 1, 32'h1111_2222);     // R3 write hit
    do_req(32'h0000_0108, 0, 0);                 // R3 read back
    do_req(32'h0000_0300, 0, 0);                 // R5 dirty eviction
    for (int w = 0; w < 8; w++) do_req(32'h0000_0300 + 32'(w * 4), 0, 0);  // R7 order
    do_req(32'h0000_0100, 0, 0);                 // R9 clean eviction
    do_req(32'h0000_0A44, 1, 32'hCAFE_F00D);     // R8 write miss allocates
    do_req(32'h0000_0A44, 0, 0);
    // R1: I/O access is ignored
    @(negedge clk);
    aq_valid = 1; aq_addr = 32'h8000_0100; aq_write = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(!aq_pop && !rq_push && !wq_pop, "R1 io ignored", {aq_pop, rq_push, wq_pop}, 0);
    end
    aq_valid = 0;
    for (int k = 0; k < 40; k++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      ra = {21'd0, 2'(r[1:0] % 2'd3), 4'd2 + 4'(r[2]), r[5:3], 2'b00};
      do_req(ra, r[6], {r, ~r});
    end
    repeat (5) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule